// File: doc/BRIEF.md
# Command-Register I2C Byte Master

This block is a single-byte I2C master that a processor drives through four byte-wide command registers. Each bus transaction moves exactly one data byte between the master and one register of one slave device, for example the seconds register of a real-time clock. Software first stores the direction, the 7-bit slave address and the slave register index, in any order. It then writes the lowest command byte. That last write both supplies the data byte and launches the transaction.

The master drives SCL and SDA as open-drain lines. It only ever enables a pull-down, and a released line is pulled high outside the block. The bus clock comes from the system clock through a divider set by two frequency parameters. Each bus bit takes four equal quarter periods. While a transaction runs, a busy flag is high. A read returns its byte on a read-data output. If the slave leaves any byte unacknowledged, the master ends the transfer with STOP and raises a sticky error flag. As an example of use: a slave at register 0x00 that holds seconds halts its count when 0x00 is written there and runs again once a value with bit 7 set, such as 0x80, is written.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy, error and rd_data are all zero and neither scl_oe nor sda_oe is asserted.
- R2: Writes to command bytes 1, 2 and 3 only store their values; they never start a transaction. Byte 3 bit 7 is the direction (1 = read, 0 = write), byte 2 bits 6:0 are the slave address, and byte 1 is the slave register index.
- R3: A write to command byte 0 while idle starts one transaction. busy is high from the clock edge that takes that write until STOP has completed.
- R4: A write transaction sends START, the address byte with bit 0 = 0, the register index, the byte-0 value as data, then STOP. All bytes are sent MSB first.
- R5: A read transaction sends START, the address with bit 0 = 0, the register index, a repeated START, the address with bit 0 = 1, and then clocks in one byte. The master answers that byte with NACK, sends STOP and presents the byte on rd_data. The byte-0 value is not used on a read.
- R6: While SCL is released high, SDA changes only as part of a START, a repeated START or a STOP. So a write shows exactly one SDA fall and one SDA rise with SCL high, and a read shows two falls and one rise.
- R7: A write to byte 0 while busy is ignored. It neither changes the data of the running transfer nor starts another one.
- R8: A missing ACK after any master-sent byte aborts the transfer with STOP and sets error. On a failed read, rd_data keeps its old value.
- R9: error stays set until the next accepted byte-0 write, which clears it on that same clock edge.
- R10: The lines are only pulled low through scl_oe and sda_oe. Whenever busy is low, both enables are deasserted.
- R11: One SCL bit period lasts 4 x QUARTER system clocks plus at most 3 cycles of turnaround between symbols, where QUARTER = CLK_HZ / (4 x SCL_HZ).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command register write strobe |
| wr_addr | input | 2 | Command byte index 0..3 |
| wr_data | input | 8 | Value written to the selected byte |
| busy | output | 1 | Transaction in progress |
| error | output | 1 | Sticky missing-ACK flag |
| rd_data | output | 8 | Byte returned by the last successful read |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The checker watches on every cycle that busy only rises after a byte-0 write, that error only rises inside a transaction and only falls on an accepted trigger, that both enables are released whenever the block is idle, and that SDA moves under a high SCL only inside a START or STOP symbol. The bench runs against a behavioural slave with a small register file. Only its scenarios can show the byte order on the wire, the returned read data, the effect of a NACK from an absent address or a refusing slave, the dropped trigger while busy, and the measured SCL bit period.

// File: rtl/i2c_cmd_pkg.sv
// Shared types and helpers for the command-register I2C master.
// Assumes: one bus symbol spans four quarter periods, numbered 0..3.
package i2c_cmd_pkg;

    // Command byte indices as seen by the host write port
    localparam logic [1:0] CMD_DATA = 2'd0;  // data byte, also the trigger
    localparam logic [1:0] CMD_REG  = 2'd1;  // slave register index
    localparam logic [1:0] CMD_ADDR = 2'd2;  // 7-bit slave address
    localparam logic [1:0] CMD_CTRL = 2'd3;  // bit 7 selects read

    // Bus symbols the line engine can produce
    typedef enum logic [1:0] {
        SYM_START,
        SYM_BIT,
        SYM_STOP
    } sym_e;

    // Transaction sequencer steps
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDRW,
        ST_REG,
        ST_WDATA,
        ST_RSTART,
        ST_ADDRR,
        ST_RDATA,
        ST_STOP
    } step_e;

    // One latched command
    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [7:0] idx;
        logic [7:0] data;
    } cmd_t;

    // Released-line levels {scl, sda} for a symbol in a given quarter.
    // START begins with SCL low so it also serves as repeated START.
    function automatic logic [1:0] sym_levels(sym_e s, logic b, logic [1:0] q);
        logic [1:0] lv;
        case (s)
            SYM_START: begin
                case (q)
                    2'd0:    lv = 2'b01;
                    2'd1:    lv = 2'b11;
                    2'd2:    lv = 2'b10;
                    default: lv = 2'b00;
                endcase
            end
            SYM_STOP: begin
                case (q)
                    2'd0:    lv = 2'b00;
                    2'd1:    lv = 2'b10;
                    default: lv = 2'b11;
                endcase
            end
            default: lv = {(q == 2'd1) || (q == 2'd2), b};
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/i2c_cmd_regs.sv
// Command register bank: stores direction, address and register index,
// and turns a byte-0 write taken while idle into a one-cycle trigger.
// Assumes: byte 0 is not stored; its value travels with the trigger.
module i2c_cmd_regs
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       busy,
    output logic       trigger,
    output cmd_t       cmd
);

    logic       rd_q;
    logic [6:0] addr_q;
    logic [7:0] idx_q;

    // Store the upper command bytes; these writes have no other effect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                CMD_CTRL: rd_q   <= wr_data[7];
                CMD_ADDR: addr_q <= wr_data[6:0];
                CMD_REG:  idx_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    // A byte-0 write launches a transfer only while the master is idle
    always_comb begin
        trigger = wr_en && (wr_addr == CMD_DATA) && !busy;
    end

    // Present the complete command, with data taken straight from the bus
    always_comb begin
        cmd.rd   = rd_q;
        cmd.addr = addr_q;
        cmd.idx  = idx_q;
        cmd.data = wr_data;
    end

endmodule

// File: rtl/i2c_cmd_tick.sv
// Quarter-period tick generator for the SCL timing.
// Assumes: en is held high for a whole symbol; the count restarts when en drops.
module i2c_cmd_tick #(
    parameter int unsigned QUARTER = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int unsigned CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

    logic [CW-1:0] cnt;

    // Tick on the last cycle of each quarter
    always_comb begin
        tick = en && (cnt == LAST);
    end

    // Count system clocks inside a quarter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cmd_engine.sv
// Line engine: plays one bus symbol (START, data bit, STOP) over four
// quarters, drives the open-drain enables and samples SDA mid SCL-high.
// Assumes: go arrives only while not active; sda_in may be asynchronous.
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  sym_e sym,
    input  logic bitv,
    input  logic tick,
    input  logic sda_in,
    output logic active,
    output logic done,
    output logic sampled,
    output sym_e cur_sym,
    output logic scl_oe,
    output logic sda_oe
);

    logic [SYNC_STAGES-1:0] sda_sync;
    logic [1:0]             q;
    logic                   cur_bit;
    logic                   scl_lvl;
    logic                   sda_lvl;

    // Bring the SDA line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_sync <= '1;
        end else begin
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
        end
    end

    // Step through the quarters of the current symbol
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            done    <= 1'b0;
            q       <= 2'd0;
            cur_sym <= SYM_STOP;
            cur_bit <= 1'b1;
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            sampled <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active             <= 1'b1;
                    q                  <= 2'd0;
                    cur_sym            <= sym;
                    cur_bit            <= bitv;
                    {scl_lvl, sda_lvl} <= sym_levels(sym, bitv, 2'd0);
                end
            end else if (tick) begin
                if (q == 2'd1) begin
                    sampled <= sda_sync[SYNC_STAGES-1];
                end
                if (q == 2'd3) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    q                  <= q + 2'd1;
                    {scl_lvl, sda_lvl} <= sym_levels(cur_sym, cur_bit, q + 2'd1);
                end
            end
        end
    end

    // A low level is produced only by enabling the pull-down
    always_comb begin
        scl_oe = ~scl_lvl;
        sda_oe = ~sda_lvl;
    end

endmodule

// File: rtl/i2c_cmd_seq.sv
// Transaction sequencer: orders the symbols of a single-byte register
// write or read, checks each ACK and collects the read byte.
// Assumes: the engine reports done one cycle after its last quarter.
module i2c_cmd_seq
    import i2c_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trigger,
    input  cmd_t       cmd_in,
    input  logic       sym_done,
    input  logic       sampled,
    output logic       go,
    output sym_e       sym,
    output logic       bitv,
    output logic       busy,
    output logic       error,
    output logic [7:0] rd_data
);

    step_e      step;
    cmd_t       cmd_q;
    logic [7:0] sh;
    logic [7:0] rx;
    logic [3:0] bitn;

    // Advance the transaction each time a symbol completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= ST_IDLE;
            cmd_q   <= '0;
            sh      <= '0;
            rx      <= '0;
            bitn    <= '0;
            go      <= 1'b0;
            sym     <= SYM_STOP;
            bitv    <= 1'b1;
            busy    <= 1'b0;
            error   <= 1'b0;
            rd_data <= '0;
        end else begin
            go <= 1'b0;
            if (step == ST_IDLE) begin
                if (trigger) begin
                    cmd_q <= cmd_in;
                    busy  <= 1'b1;
                    error <= 1'b0;
                    step  <= ST_START;
                    go    <= 1'b1;
                    sym   <= SYM_START;
                    bitv  <= 1'b1;
                end
            end else if (sym_done) begin
                case (step)
                    ST_START, ST_RSTART: begin
                        step <= (step == ST_START) ? ST_ADDRW : ST_ADDRR;
                        sh   <= {cmd_q.addr, step == ST_RSTART};
                        bitn <= 4'd0;
                        go   <= 1'b1;
                        sym  <= SYM_BIT;
                        bitv <= cmd_q.addr[6];
                    end
                    ST_ADDRW, ST_REG, ST_WDATA, ST_ADDRR: begin
                        if (bitn < 4'd7) begin
                            sh   <= sh << 1;
                            bitn <= bitn + 4'd1;
                            go   <= 1'b1;
                            sym  <= SYM_BIT;
                            bitv <= sh[6];
                        end else if (bitn == 4'd7) begin
                            bitn <= 4'd8;
                            go   <= 1'b1;
                            sym  <= SYM_BIT;
                            bitv <= 1'b1;
                        end else if (sampled) begin
                            error <= 1'b1;
                            step  <= ST_STOP;
                            go    <= 1'b1;
                            sym   <= SYM_STOP;
                        end else begin
                            bitn <= 4'd0;
                            go   <= 1'b1;
                            case (step)
                                ST_ADDRW: begin
                                    step <= ST_REG;
                                    sh   <= cmd_q.idx;
                                    sym  <= SYM_BIT;
                                    bitv <= cmd_q.idx[7];
                                end
                                ST_REG: begin
                                    if (cmd_q.rd) begin
                                        step <= ST_RSTART;
                                        sym  <= SYM_START;
                                        bitv <= 1'b1;
                                    end else begin
                                        step <= ST_WDATA;
                                        sh   <= cmd_q.data;
                                        sym  <= SYM_BIT;
                                        bitv <= cmd_q.data[7];
                                    end
                                end
                                ST_ADDRR: begin
                                    step <= ST_RDATA;
                                    sym  <= SYM_BIT;
                                    bitv <= 1'b1;
                                end
                                default: begin
                                    step <= ST_STOP;
                                    sym  <= SYM_STOP;
                                end
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        go <= 1'b1;
                        if (bitn < 4'd8) begin
                            rx   <= {rx[6:0], sampled};
                            bitn <= bitn + 4'd1;
                            sym  <= SYM_BIT;
                            bitv <= 1'b1;
                        end else begin
                            rd_data <= rx;
                            step    <= ST_STOP;
                            sym     <= SYM_STOP;
                        end
                    end
                    default: begin
                        busy <= 1'b0;
                        step <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cmd_master.sv
// Top: single-byte I2C register master under four command bytes.
// Assumes: external pull-ups on both lines; CLK_HZ >= 4 * SCL_HZ.
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned SCL_HZ      = 100_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       busy,
    output logic       error,
    output logic [7:0] rd_data,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);

    localparam int unsigned QUARTER = CLK_HZ / (4 * SCL_HZ);

    logic trigger;
    cmd_t cmd;
    logic go;
    sym_e sym;
    logic bitv;
    logic tick;
    logic active;
    logic sym_done;
    logic sampled;
    sym_e engine_sym;

    i2c_cmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .trigger (trigger),
        .cmd     (cmd)
    );

    i2c_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (trigger),
        .cmd_in   (cmd),
        .sym_done (sym_done),
        .sampled  (sampled),
        .go       (go),
        .sym      (sym),
        .bitv     (bitv),
        .busy     (busy),
        .error    (error),
        .rd_data  (rd_data)
    );

    i2c_cmd_tick #(.QUARTER(QUARTER)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .tick  (tick)
    );

    i2c_cmd_engine #(.SYNC_STAGES(SYNC_STAGES)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .sym     (sym),
        .bitv    (bitv),
        .tick    (tick),
        .sda_in  (sda_in),
        .active  (active),
        .done    (sym_done),
        .sampled (sampled),
        .cur_sym (engine_sym),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

endmodule

// File: rtl/i2c_cmd_master_chk.sv
// Protocol checker for the command-register I2C master, bound to the top.
module i2c_cmd_master_chk
    import i2c_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       busy,
    input logic       error,
    input logic       scl_oe,
    input logic       sda_oe,
    input sym_e       engine_sym
);

    // R3: a transaction only begins after a byte-0 write
    assert_busy_from_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && (wr_addr == CMD_DATA)));

    // R8: the error flag is raised only inside a transaction
    assert_error_in_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> busy);

    // R9: the error flag clears only on an accepted trigger
    assert_error_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error) |-> $past(wr_en && (wr_addr == CMD_DATA) && !busy));

    // R10: both lines are released whenever the master is idle
    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R6: SDA moves under a high SCL only inside START or STOP symbols
    assert_sda_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (engine_sym != SYM_BIT));

endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .busy       (busy),
    .error      (error),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .engine_sym (engine_sym)
);

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned T_CLK      = 4_000_000;
    localparam int unsigned T_SCL      = 100_000;
    localparam int unsigned QTR        = T_CLK / (4 * T_SCL);
    localparam logic [6:0]  SLV        = 7'h6F;
    localparam int          NVEC       = 8;

    // {rd, addr, reg, data, exp_err, exp_value}
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b0, 7'h6F, 8'h00, 8'h80, 1'b0, 8'h80},
        {1'b1, 7'h6F, 8'h00, 8'hFF, 1'b0, 8'h80},
        {1'b0, 7'h6F, 8'h00, 8'h00, 1'b0, 8'h00},
        {1'b1, 7'h6F, 8'h00, 8'hC3, 1'b0, 8'h00},
        {1'b0, 7'h6F, 8'h05, 8'hA5, 1'b0, 8'hA5},
        {1'b1, 7'h6F, 8'h05, 8'h3C, 1'b0, 8'hA5},
        {1'b0, 7'h50, 8'h01, 8'h77, 1'b1, 8'h11},
        {1'b1, 7'h50, 8'h01, 8'h00, 1'b1, 8'hA5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       busy;
    logic       error;
    logic [7:0] rd_data;
    logic       scl_oe;
    logic       sda_oe;
    logic       slv_pull;
    logic       scl_bus;
    logic       sda_bus;

    int checks = 0;
    int errors = 0;

    assign scl_bus = ~scl_oe;
    assign sda_bus = ~(sda_oe | slv_pull);

    i2c_cmd_master #(.CLK_HZ(T_CLK), .SCL_HZ(T_SCL)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .error   (error),
        .rd_data (rd_data),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe),
        .sda_in  (sda_bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural slave: 16 registers, one address, optional data refusal
    logic [7:0] slv_mem [16];
    logic       nack_data = 1'b0;
    logic       p_scl, p_sda, in_ack;
    int         st, bc;
    logic [7:0] shr, tx;
    logic [3:0] ptr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) slv_mem[i] <= 8'h10 + 8'(i);
            p_scl <= 1'b1; p_sda <= 1'b1; in_ack <= 1'b0;
            st <= 0; bc <= 0; shr <= '0; tx <= '0; ptr <= '0; slv_pull <= 1'b0;
        end else begin
            p_scl <= scl_bus;
            p_sda <= sda_bus;
            if (p_scl && scl_bus && p_sda && !sda_bus) begin
                st <= 1; bc <= 0; in_ack <= 1'b0; slv_pull <= 1'b0;
            end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
                st <= 0; in_ack <= 1'b0; slv_pull <= 1'b0;
            end else if (st != 0) begin
                if (!p_scl && scl_bus) begin
                    if (bc < 8) shr <= {shr[6:0], sda_bus};
                    bc <= bc + 1;
                end else if (p_scl && !scl_bus) begin
                    if (in_ack) begin
                        in_ack   <= 1'b0;
                        bc       <= 0;
                        slv_pull <= (st == 4) ? ~tx[7] : 1'b0;
                    end else if (bc == 8) begin
                        case (st)
                            1: begin
                                if (shr[7:1] == SLV) begin
                                    slv_pull <= 1'b1; in_ack <= 1'b1;
                                    if (shr[0]) begin st <= 4; tx <= slv_mem[ptr]; end
                                    else st <= 2;
                                end else st <= 0;
                            end
                            2: begin ptr <= shr[3:0]; slv_pull <= 1'b1; in_ack <= 1'b1; st <= 3; end
                            3: begin
                                if (!nack_data) begin
                                    slv_mem[ptr] <= shr; slv_pull <= 1'b1; in_ack <= 1'b1;
                                end else st <= 0;
                            end
                            default: slv_pull <= 1'b0;
                        endcase
                    end else if (st == 4 && bc < 8) begin
                        slv_pull <= ~tx[3'(7 - bc)];
                    end
                end
            end
        end
    end

    // Bus monitor: SDA edges seen while SCL stays high
    logic m_scl = 1'b1, m_sda = 1'b1;
    int   hi_falls = 0, hi_rises = 0;
    always @(posedge clk) begin
        if (m_scl && scl_bus && m_sda && !sda_bus) hi_falls++;
        if (m_scl && scl_bus && !m_sda && sda_bus) hi_rises++;
        m_scl <= scl_bus;
        m_sda <= sda_bus;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] idx, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = idx; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_cmd(input logic rd, input logic [6:0] addr, input logic [7:0] idx);
        write_reg(2'd3, rd ? 8'h80 : 8'h00);
        write_reg(2'd2, {1'b0, addr});
        write_reg(2'd1, idx);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", checks, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0, r0, t0, per;
        logic ps;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 busy", 32'(busy), 0);
        check(error == 1'b0, "R1 error", 32'(error), 0);
        check(rd_data == 8'h00, "R1 rd_data", 32'(rd_data), 0);
        check(!scl_oe && !sda_oe, "R1 enables", {30'd0, scl_oe, sda_oe}, 0);

        // R2: upper bytes only store
        load_cmd(1'b0, SLV, 8'h00);
        repeat (30) @(negedge clk);
        check(!busy && !scl_oe && !sda_oe, "R2 no start", {29'd0, busy, scl_oe, sda_oe}, 0);

        // Table walk: R3 start, R4 writes, R5 reads, R8 absent slave
        for (int v = 0; v < NVEC; v++) begin
            logic        rd   = VECS[v][32];
            logic [6:0]  ad   = VECS[v][31:25];
            logic [7:0]  ix   = VECS[v][24:17];
            logic [7:0]  dt   = VECS[v][16:9];
            logic        xerr = VECS[v][8];
            logic [7:0]  xval = VECS[v][7:0];
            load_cmd(rd, ad, ix);
            write_reg(2'd0, dt);
            check(busy == 1'b1, "R3 busy after trigger", 32'(busy), 1);
            wait_idle();
            check(error == xerr, xerr ? "R8 error set" : "R4/R5 no error", 32'(error), 32'(xerr));
            if (rd) begin
                check(rd_data == xval, xerr ? "R8 rd_data kept" : "R5 read data", 32'(rd_data), 32'(xval));
                if (!xerr)
                    check(slv_mem[ix[3:0]] == xval, "R5 byte0 unused", 32'(slv_mem[ix[3:0]]), 32'(xval));
            end else begin
                check(slv_mem[ix[3:0]] == xval, xerr ? "R8 no store" : "R4 write data", 32'(slv_mem[ix[3:0]]), 32'(xval));
            end
        end

        // R10: bus idle after the table
        repeat (5) @(negedge clk);
        check(scl_bus && sda_bus && !scl_oe && !sda_oe, "R10 lines released", {30'd0, scl_bus, sda_bus}, 3);

        // R6: SDA edges with SCL high
        f0 = hi_falls; r0 = hi_rises;
        load_cmd(1'b0, SLV, 8'h07);
        write_reg(2'd0, 8'h42);
        wait_idle();
        repeat (5) @(negedge clk);
        check((hi_falls - f0) == 1 && (hi_rises - r0) == 1, "R6 write edges",
              32'((hi_falls - f0) * 16 + (hi_rises - r0)), 32'h11);
        f0 = hi_falls; r0 = hi_rises;
        load_cmd(1'b1, SLV, 8'h07);
        write_reg(2'd0, 8'h00);
        wait_idle();
        repeat (5) @(negedge clk);
        check((hi_falls - f0) == 2 && (hi_rises - r0) == 1, "R6 read edges",
              32'((hi_falls - f0) * 16 + (hi_rises - r0)), 32'h21);
        check(rd_data == 8'h42, "R5 read back", 32'(rd_data), 32'h42);

        // R11: SCL bit period
        load_cmd(1'b1, SLV, 8'h07);
        write_reg(2'd0, 8'h00);
        begin
            int rises = 0;
            int cyc = 0;
            t0 = 0; per = 0;
            ps = scl_bus;
            while (rises < 4 && cyc < 5000) begin
                @(negedge clk);
                cyc++;
                if (!ps && scl_bus) begin
                    rises++;
                    if (rises == 3) t0 = cyc;
                    if (rises == 4) per = cyc - t0;
                end
                ps = scl_bus;
            end
        end
        check(per >= int'(4 * QTR) && per <= int'(4 * QTR + 3), "R11 bit period", 32'(per), 32'(4 * QTR));
        wait_idle();

        // R7: byte-0 write during a transfer is dropped
        load_cmd(1'b0, SLV, 8'h06);
        write_reg(2'd0, 8'h33);
        repeat (200) @(negedge clk);
        write_reg(2'd0, 8'h44);
        wait_idle();
        check(slv_mem[6] == 8'h33, "R7 data unchanged", 32'(slv_mem[6]), 32'h33);
        repeat (100) @(negedge clk);
        check(!busy && !scl_oe, "R7 no second transfer", {30'd0, busy, scl_oe}, 0);
        check(slv_mem[6] == 8'h33, "R7 final data", 32'(slv_mem[6]), 32'h33);

        // R8 and R9: slave refuses the data byte
        nack_data = 1'b1;
        load_cmd(1'b0, SLV, 8'h02);
        write_reg(2'd0, 8'h99);
        wait_idle();
        check(error == 1'b1, "R8 data nack", 32'(error), 1);
        check(slv_mem[2] == 8'h12, "R8 refused data", 32'(slv_mem[2]), 32'h12);
        check(!scl_oe && !sda_oe, "R8 stop issued", {30'd0, scl_oe, sda_oe}, 0);
        repeat (100) @(negedge clk);
        check(error == 1'b1, "R9 sticky", 32'(error), 1);
        nack_data = 1'b0;
        write_reg(2'd0, 8'h55);
        check(error == 1'b0, "R9 cleared on trigger", 32'(error), 0);
        wait_idle();
        check(error == 1'b0 && slv_mem[2] == 8'h55, "R9 clean transfer", 32'(slv_mem[2]), 32'h55);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule